// File: doc/BRIEF.md
# Palette Colour Table Write Sequencer

This block holds a colour lookup table of 256 entries, each made of a red, a green and a blue byte. A host loads the table through a small write-only register window of 16 bytes. A write to one register picks the table entry. Each following write to a second register fills one colour component of that entry, and the components are taken in a fixed red, green, blue rotation. Once blue is written, the entry pointer moves on to the next entry by itself, so a host can stream a whole palette after setting the start entry once.

The colour value always comes from the most significant byte of the 32-bit host word, and the entry number comes from the same byte. The lower bits are ignored. A separate pixel lookup port takes a pixel value as the table address and returns the 24-bit colour one clock later. This port runs independently of host writes. Reads from the host window always return zero.

Top module: `clut_wseq`

## Requirements
- R1: After reset, every entry reads as 0x000000 except entry 255, which reads as 0xFFFFFF. The entry pointer is 0 and the rotation stands at red, so data writes with no prior select fill entry 0.
- R2: A write to byte offset 0 loads the entry pointer from host data bits 31:24 and sets the rotation to red. Lower data bits have no effect.
- R3: Each write to byte offset 4 stores host data bits 31:24 into one component of the pointed entry, in the order red, green, blue. The colour word is packed as red in bits 23:16, green in 15:8 and blue in 7:0.
- R4: A data write in the blue step increments the entry pointer modulo 256, so 255 wraps to 0, and returns the rotation to red.
- R5: A select write in the middle of a rotation restarts it at red. Components already written stay in the table.
- R6: A write to any offset other than 0 and 4 (for example 1, 5, 8 or 12) changes neither the table, the pointer nor the rotation.
- R7: The host read data output is always zero.
- R8: A lookup returns the colour of entry `pix_idx` at the next clock. A component written at a given clock edge is visible to a lookup issued after that edge. A lookup issued in the same cycle as the write returns the old value.
- R9: Lookups proceed every cycle during a stream of host writes and always return the table contents as they stood at the lookup edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 4 | Byte offset within the register window |
| wr_data | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, always zero |
| pix_idx | input | 8 | Pixel value used as the table address |
| pix_rgb | output | 24 | Colour of the addressed entry, one cycle later |

## Verification
Two functions can land in the same clock: a host component write and a pixel lookup of the very entry being written. The bench provokes this by holding the lookup address on the entry while the data write is strobed. It expects the old colour on the next cycle and the new colour on the cycle after. It then streams writes while sweeping the lookup address, and checks every cycle against a reference model. That model samples its table before applying the write of the same edge.

// File: rtl/clut_pkg.sv
package clut_pkg;
   // component rotation step; encoding 3 is unused and recovers to red
   typedef enum logic [1:0] {
      PH_RED = 2'd0,
      PH_GRN = 2'd1,
      PH_BLU = 2'd2
   } phase_e;

   localparam int NUM_COMP = 3;
endpackage

// File: rtl/clut_host_decode.sv
module clut_host_decode #(
   parameter int ADDR_W   = 4,
   parameter int SEL_OFS  = 0,
   parameter int DATA_OFS = 4
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic              idx_we,
   output logic              dat_we
);
   localparam logic [ADDR_W-1:0] SEL_A = ADDR_W'(SEL_OFS);
   localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(DATA_OFS);

   always_comb begin
      idx_we = wr_en && (wr_addr == SEL_A);
      dat_we = wr_en && (wr_addr == DAT_A);
   end
endmodule

// File: rtl/clut_seq.sv
module clut_seq
   import clut_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                idx_we,
   input  logic                dat_we,
   input  logic [DATA_W-1:0]   wr_data,
   output logic [IDX_W-1:0]    cur_idx,
   output phase_e              cur_phase,
   output logic [NUM_COMP-1:0] comp_we
);
   logic [IDX_W-1:0] sel_val;
   assign sel_val = wr_data[DATA_W-1 -: IDX_W];

   logic unused_low_data;
   assign unused_low_data = ^wr_data[DATA_W-IDX_W-1:0];

   always_comb begin
      comp_we = '0;
      if (dat_we) begin
         case (cur_phase)
            PH_RED:  comp_we[0] = 1'b1;
            PH_GRN:  comp_we[1] = 1'b1;
            PH_BLU:  comp_we[2] = 1'b1;
            default: comp_we    = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_idx   <= '0;
         cur_phase <= PH_RED;
      end else if (idx_we) begin
         cur_idx   <= sel_val;
         cur_phase <= PH_RED;
      end else if (dat_we) begin
         case (cur_phase)
            PH_RED:  cur_phase <= PH_GRN;
            PH_GRN:  cur_phase <= PH_BLU;
            PH_BLU: begin
               cur_idx   <= cur_idx + 1'b1;
               cur_phase <= PH_RED;
            end
            default: cur_phase <= PH_RED;
         endcase
      end
   end
endmodule

// File: rtl/clut_store.sv
module clut_store
   import clut_pkg::*;
#(
   parameter int IDX_W  = 8,
   parameter int COMP_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_COMP-1:0]        comp_we,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic [COMP_W-1:0]          wr_val,
   input  logic [IDX_W-1:0]           rd_idx,
   output logic [NUM_COMP*COMP_W-1:0] rd_rgb
);
   localparam int ENTRIES = 1 << IDX_W;

   // one bank per component; bank 0 (red) lands in the top byte
   for (genvar c = 0; c < NUM_COMP; c++) begin : g_bank
      logic [COMP_W-1:0] mem [ENTRIES];
      logic [COMP_W-1:0] rd_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++)
               mem[i] <= (i == ENTRIES - 1) ? '1 : '0;
            rd_q <= '0;
         end else begin
            if (comp_we[c])
               mem[wr_idx] <= wr_val;
            rd_q <= mem[rd_idx];
         end
      end

      assign rd_rgb[(NUM_COMP-1-c)*COMP_W +: COMP_W] = rd_q;
   end
endmodule

// File: rtl/clut_wseq.sv
module clut_wseq
   import clut_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 8,
   parameter int COMP_W = 8,
   parameter int ADDR_W = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   output logic [DATA_W-1:0]          host_rdata,
   input  logic [IDX_W-1:0]           pix_idx,
   output logic [NUM_COMP*COMP_W-1:0] pix_rgb
);
   if (COMP_W >= DATA_W || IDX_W >= DATA_W) begin : g_bad_width
      $error("clut_wseq: component and index fields must be narrower than the data word");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("clut_wseq: address must reach byte offset 4");
   end

   logic                idx_we;
   logic                dat_we;
   logic [IDX_W-1:0]    cur_idx;
   phase_e              cur_phase;
   logic [NUM_COMP-1:0] comp_we;
   logic [COMP_W-1:0]   comp_val;

   assign comp_val   = wr_data[DATA_W-1 -: COMP_W];
   assign host_rdata = '0;

   clut_host_decode #(.ADDR_W(ADDR_W), .SEL_OFS(0), .DATA_OFS(4)) u_dec (
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .idx_we  (idx_we),
      .dat_we  (dat_we)
   );

   clut_seq #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx_we    (idx_we),
      .dat_we    (dat_we),
      .wr_data   (wr_data),
      .cur_idx   (cur_idx),
      .cur_phase (cur_phase),
      .comp_we   (comp_we)
   );

   clut_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .comp_we (comp_we),
      .wr_idx  (cur_idx),
      .wr_val  (comp_val),
      .rd_idx  (pix_idx),
      .rd_rgb  (pix_rgb)
   );
endmodule

// File: rtl/clut_wseq_chk.sv
module clut_wseq_chk #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 8,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [IDX_W-1:0]  cur_idx,
   input logic [1:0]        cur_phase,
   input logic [2:0]        comp_we
);
   logic sel_wr, dat_wr;
   assign sel_wr = wr_en && (wr_addr == ADDR_W'(0));
   assign dat_wr = wr_en && (wr_addr == ADDR_W'(4));

   // R2
   idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_wr |=> (cur_idx == $past(wr_data[DATA_W-1 -: IDX_W])) && (cur_phase == 2'd0));

   // R3
   red_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && cur_phase == 2'd0) |=> (cur_phase == 2'd1) && $stable(cur_idx));

   // R3
   green_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && cur_phase == 2'd1) |=> (cur_phase == 2'd2) && $stable(cur_idx));

   // R4
   blue_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && cur_phase == 2'd2) |=> (cur_idx == IDX_W'($past(cur_idx) + 1'b1)) && (cur_phase == 2'd0));

   // R6
   ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_wr && !dat_wr) |=> $stable(cur_idx) && $stable(cur_phase));

   // R3
   one_comp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(comp_we) && (dat_wr || comp_we == 3'b000));
endmodule

bind clut_wseq clut_wseq_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .cur_idx   (cur_idx),
   .cur_phase (cur_phase),
   .comp_we   (comp_we)
);

// File: tb/clut_wseq_tb.sv
`timescale 1ns/1ps
module clut_wseq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] host_rdata;
   logic [7:0]  pix_idx = '0;
   logic [23:0] pix_rgb;

   int checks = 0;
   int fails  = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   clut_wseq u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .host_rdata(host_rdata), .pix_idx(pix_idx), .pix_rgb(pix_rgb)
   );

   // behavioural reference model
   int mr[256], mg[256], mb[256];
   int m_idx, m_ph;
   logic [23:0] exp_rgb = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) begin
            mr[i] = (i == 255) ? 255 : 0;
            mg[i] = mr[i];
            mb[i] = mr[i];
         end
         m_idx = 0; m_ph = 0;
         exp_rgb = '0;
      end else begin
         exp_rgb = {mr[pix_idx][7:0], mg[pix_idx][7:0], mb[pix_idx][7:0]};
         if (wr_en && wr_addr == 4'd0) begin
            m_idx = int'(wr_data[31:24]); m_ph = 0;
         end else if (wr_en && wr_addr == 4'd4) begin
            if (m_ph == 0) begin mr[m_idx] = int'(wr_data[31:24]); m_ph = 1; end
            else if (m_ph == 1) begin mg[m_idx] = int'(wr_data[31:24]); m_ph = 2; end
            else begin mb[m_idx] = int'(wr_data[31:24]); m_idx = (m_idx + 1) % 256; m_ph = 0; end
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk(cur_req, {8'h0, pix_rgb}, {8'h0, exp_rgb});
         chk("R7", host_rdata, 32'h0);
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_addr = 4'hF; wr_data = 32'hDEAD_BEEF;
   endtask

   task automatic look(input string req, input logic [7:0] idx, input logic [23:0] exp);
      @(negedge clk);
      pix_idx = idx;
      @(negedge clk);
      chk(req, {8'h0, pix_rgb}, {8'h0, exp});
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset contents
      cur_req = "R1";
      look("R1", 8'd255, 24'hFFFFFF);
      look("R1", 8'd0,   24'h000000);
      look("R1", 8'd17,  24'h000000);
      chk("R7", host_rdata, 32'h0);
      // R1 pointer and rotation cleared: data fills entry 0
      wr(4'd4, 32'hAA00_0000);
      wr(4'd4, 32'hBB12_3456);
      wr(4'd4, 32'hCCFF_FFFF);
      look("R1", 8'd0, 24'hAABBCC);
      // R2/R3 select with garbage low bits
      cur_req = "R3";
      wr(4'd0, 32'h10FF_FFFF);
      wr(4'd4, 32'h1201_0101);
      wr(4'd4, 32'h34FF_0000);
      wr(4'd4, 32'h5600_00FF);
      look("R2", 8'h10, 24'h123456);
      look("R3", 8'h11, 24'h000000);
      // R5 restart mid-rotation
      cur_req = "R5";
      wr(4'd0, 32'h2000_0000);
      wr(4'd4, 32'h1100_0000);
      wr(4'd4, 32'h2200_0000);
      look("R8", 8'h20, 24'h112200);
      wr(4'd0, 32'h2000_0000);
      wr(4'd4, 32'h3300_0000);
      wr(4'd4, 32'h4400_0000);
      wr(4'd4, 32'h5500_0000);
      look("R5", 8'h20, 24'h334455);
      // R4 wrap from 255 to 0
      cur_req = "R4";
      wr(4'd0, 32'hFF00_0000);
      wr(4'd4, 32'h0100_0000);
      wr(4'd4, 32'h0200_0000);
      wr(4'd4, 32'h0300_0000);
      look("R4", 8'hFF, 24'h010203);
      wr(4'd4, 32'h0A00_0000);
      look("R4", 8'h00, 24'h0ABBCC);
      // R6 ignored offsets; rotation now at green on entry 0
      cur_req = "R6";
      wr(4'd8,  32'h9900_0000);
      wr(4'd12, 32'h9800_0000);
      wr(4'd1,  32'h9700_0000);
      wr(4'd5,  32'h9600_0000);
      look("R6", 8'h00, 24'h0ABBCC);
      look("R6", 8'h97, 24'h000000);
      wr(4'd4, 32'h6600_0000);
      look("R6", 8'h00, 24'h0A66CC);
      // R8 same-cycle write and lookup of one entry
      cur_req = "R8";
      wr(4'd0, 32'h4000_0000);
      @(negedge clk);
      pix_idx = 8'h40; wr_en = 1'b1; wr_addr = 4'd4; wr_data = 32'hE100_0000;
      @(negedge clk);
      wr_en = 1'b0; wr_addr = 4'hF;
      chk("R8", {8'h0, pix_rgb}, 32'h0);
      @(negedge clk);
      chk("R8", {8'h0, pix_rgb}, 32'h00E1_0000);
      // R9 stream of writes with a sweeping lookup
      cur_req = "R9";
      wr(4'd0, 32'h3E00_0000);
      for (int i = 0; i < 96; i++) begin
         @(negedge clk);
         wr_en = (i % 5) != 4;
         wr_addr = 4'd4;
         wr_data = {8'(i * 7 + 3), 24'h0};
         pix_idx = 8'(8'h3C + (i % 12));
      end
      @(negedge clk);
      wr_en = 1'b0;
      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule